// File: doc/BRIEF.md
# Snapshot Capture Buffer Controller

The block records a burst of 12-bit converter samples into an on-chip buffer at the full sample clock rate and then plays the burst back at one eighth of that rate. Downstream logic can take the samples at a relaxed pace and at a time it chooses. Everything runs on the single sample clock. The buffer depth is `2**ADDR_W` entries. The production setting is `ADDR_W = 14`, which gives 16384 entries. The default parameter value is smaller so that elaboration stays light.

There are two capture behaviours. In one-shot mode, an arm command or a fill strobe starts a capture, and the capture stops by itself once the buffer is full. In streaming mode, the arm command starts writing with wrap-around, and the fill strobe freezes the buffer so that it holds the most recent samples. A dump request drains the buffer, oldest sample first. Each word can be coded as offset binary, two's complement or Gray. Each word goes out either as one 12-bit parallel word or as two 6-bit halves on the two edges of an output clock. A data-valid qualifier frames every word. Full and empty flags report how much the buffer holds.

Top module: `snap_capture_buf`

## Requirements
- R1: After reset, `empty_o`=1, `full_o`=0, `pvalid_o`=0, `pclk_o`=0 and `pdat_o`=0.
- R2: One-shot capture (`stream_mode_i`=0):
  - When the controller is idle, `arm_i` or `fill_i` sampled high at edge E starts a capture and discards earlier contents.
  - The samples present at edges E+1 through E+DEPTH are stored.
  - Writing then stops, and `full_o` is high after edge E+DEPTH.
- R3: `arm_i` and `fill_i` are ignored while a capture or a dump is in progress.
- R4: Streaming capture (`stream_mode_i`=1):
  - When idle, `arm_i` at edge E starts writing at every later edge, with wrap-around.
  - `fill_i` sampled high at an edge stops writing, and the sample at that edge is not stored.
  - The buffer then holds the most recent min(count, DEPTH) samples.
  - In streaming mode, `fill_i` does not start a capture.
- R5: `dump_i` sampled high at edge D, while idle with a non-empty buffer, starts readout, oldest sample first.
  - Word k (k from 0) appears at edge D+2+8k. `pvalid_o` rises at that same edge.
  - `pvalid_o` falls and `pdat_o` returns to 0 at edge D+8+8k, so the rate is one word per 8 clocks.
- R6: Readout drains the buffer. Each word leaves at its closing edge, `full_o` drops after the first word, and `empty_o` is high after the last word.
- R7: The output coding is taken from `code_sel_i` at the dump start edge:
  - 0 or 3: offset binary, the stored value as is.
  - 1: two's complement, with bit 11 inverted.
  - 2: Gray code, value XOR (value >> 1).
- R8: The output layout is taken from `ddr_mode_i` at the dump start edge.
  - `pclk_o` rises at D+4+8k and falls at D+7+8k.
  - In DDR mode, `pdat_o[5:0]` carries coded bits 11:6 from D+2+8k, and coded bits 5:0 from D+5+8k.
  - In DDR mode, `pdat_o[11:6]` stays 0.
  - In parallel mode, the whole coded word is held for the full valid window.
- R9: `dump_i` is ignored while the buffer is empty, and while a capture is in progress.
- R10: `full_o` is high exactly when DEPTH samples are held, and `empty_o` exactly when none are held. They are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | DATA_W | Converter sample, offset binary |
| stream_mode_i | input | 1 | 0 = one-shot capture, 1 = streaming capture |
| arm_i | input | 1 | Capture start command from the control registers |
| fill_i | input | 1 | External fill strobe: starts a one-shot capture, or stops a streaming one |
| dump_i | input | 1 | Readout request |
| code_sel_i | input | 2 | Output coding select |
| ddr_mode_i | input | 1 | 1 = half-word double-data-rate output |
| full_o | output | 1 | Buffer holds DEPTH samples |
| empty_o | output | 1 | Buffer holds no samples |
| pdat_o | output | DATA_W | Readout data |
| pclk_o | output | 1 | Readout data clock |
| pvalid_o | output | 1 | Readout word qualifier |

## Verification
A wrong write pointer or sample count shows at the ports as a flag that changes one cycle early or late. During the next dump, it shows as a first word that is not the oldest sample, or as a gap in the sample sequence. A slip in the readout phase counter moves `pvalid_o`, `pclk_o` or the DDR half swap away from its fixed offset inside the 8-clock slot. The reference model compares all five outputs on every clock, so a state error surfaces within one readout slot. For the capture flags, it surfaces on the very next edge.

// File: rtl/snap_pkg.sv
package snap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ONESHOT = 2'd1,
    ST_STREAM  = 2'd2,
    ST_DUMP    = 2'd3
  } snap_state_e;

  typedef enum logic [1:0] {
    CODE_OFFSET = 2'd0,
    CODE_TWOS   = 2'd1,
    CODE_GRAY   = 2'd2,
    CODE_RSVD   = 2'd3
  } snap_code_e;

  // Readout slot events, one per phase of the 8-clock slot.
  typedef struct packed {
    logic load;   // coded word enters the output register
    logic rise;   // output clock goes high
    logic swap;   // DDR lower half replaces upper half
    logic fall;   // output clock goes low
    logic close;  // word retired, outputs cleared
  } slot_ev_t;

  localparam int unsigned PH_W    = 3;
  localparam logic [PH_W-1:0] PH_LOAD  = 3'd1;
  localparam logic [PH_W-1:0] PH_RISE  = 3'd3;
  localparam logic [PH_W-1:0] PH_SWAP  = 3'd4;
  localparam logic [PH_W-1:0] PH_FALL  = 3'd6;
  localparam logic [PH_W-1:0] PH_CLOSE = 3'd7;

endpackage

// File: rtl/snap_store.sv
module snap_store #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (re_i) rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;

  // Storage is never written and read in the same cycle.
  assert_no_rw_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && re_i));

endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl
  import snap_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stream_mode_i,
  input  logic              arm_i,
  input  logic              fill_i,
  input  logic              dump_i,
  input  logic [1:0]        code_sel_i,
  input  logic              ddr_mode_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic              re_o,
  output logic [ADDR_W-1:0] raddr_o,
  output slot_ev_t          ev_o,
  output snap_code_e        code_o,
  output logic              ddr_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam logic [ADDR_W:0] LVL_FULL = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [ADDR_W:0] LVL_LAST = LVL_FULL - 1'b1;
  localparam logic [ADDR_W:0] LVL_ONE  = {{ADDR_W{1'b0}}, 1'b1};

  snap_state_e       state_q, state_d;
  logic [ADDR_W-1:0] wp_q, wp_d;
  logic [ADDR_W-1:0] rp_q, rp_d;
  logic [ADDR_W:0]   level_q, level_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  snap_code_e        code_q, code_d;
  logic              ddr_q, ddr_d;
  logic              start_req;
  logic              we;
  slot_ev_t          ev;

  assign start_req = arm_i | (fill_i & ~stream_mode_i);

  always_comb begin
    state_d = state_q;
    wp_d    = wp_q;
    rp_d    = rp_q;
    level_d = level_q;
    ph_d    = ph_q;
    code_d  = code_q;
    ddr_d   = ddr_q;
    we      = 1'b0;
    ev      = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (dump_i && (level_q != '0)) begin
          state_d = ST_DUMP;
          ph_d    = '0;
          rp_d    = wp_q - level_q[ADDR_W-1:0];
          code_d  = snap_code_e'(code_sel_i);
          ddr_d   = ddr_mode_i;
        end else if (start_req) begin
          state_d = stream_mode_i ? ST_STREAM : ST_ONESHOT;
          wp_d    = '0;
          level_d = '0;
        end
      end
      ST_ONESHOT: begin
        we      = 1'b1;
        wp_d    = wp_q + 1'b1;
        level_d = level_q + 1'b1;
        if (level_q == LVL_LAST) state_d = ST_IDLE;
      end
      ST_STREAM: begin
        if (fill_i) begin
          state_d = ST_IDLE;
        end else begin
          we   = 1'b1;
          wp_d = wp_q + 1'b1;
          if (level_q != LVL_FULL) level_d = level_q + 1'b1;
        end
      end
      ST_DUMP: begin
        ph_d     = ph_q + 1'b1;
        ev.load  = (ph_q == PH_LOAD);
        ev.rise  = (ph_q == PH_RISE);
        ev.swap  = (ph_q == PH_SWAP);
        ev.fall  = (ph_q == PH_FALL);
        ev.close = (ph_q == PH_CLOSE);
        if (ev.close) begin
          rp_d    = rp_q + 1'b1;
          level_d = level_q - 1'b1;
          if (level_q == LVL_ONE) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wp_q    <= '0;
      rp_q    <= '0;
      level_q <= '0;
      ph_q    <= '0;
      code_q  <= CODE_OFFSET;
      ddr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wp_q    <= wp_d;
      rp_q    <= rp_d;
      level_q <= level_d;
      ph_q    <= ph_d;
      code_q  <= code_d;
      ddr_q   <= ddr_d;
    end
  end

  assign we_o    = we;
  assign waddr_o = wp_q;
  assign re_o    = (state_q == ST_DUMP);
  assign raddr_o = rp_q;
  assign ev_o    = ev;
  assign code_o  = code_q;
  assign ddr_o   = ddr_q;
  assign full_o  = (level_q == LVL_FULL);
  assign empty_o = (level_q == '0);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVL_FULL);
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));
  assert_oneshot_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ONESHOT) |=> (level_q == $past(level_q) + 1'b1));
  assert_dump_has_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DUMP) |-> !empty_o);
  assert_capture_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ONESHOT && level_q != LVL_LAST) |=> (state_q == ST_ONESHOT));

endmodule

// File: rtl/snap_fmt.sv
module snap_fmt
  import snap_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_ev_t          ev_i,
  input  snap_code_e        code_i,
  input  logic              ddr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] pdat_o,
  output logic              pclk_o,
  output logic              pvalid_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] gray_w;
  logic [DATA_W-1:0] coded;
  logic [DATA_W-1:0] word_q, word_d;
  logic [DATA_W-1:0] pdat_q, pdat_d;
  logic              pclk_q, pclk_d;
  logic              pvalid_q, pvalid_d;

  assign gray_w[DATA_W-1] = rdata_i[DATA_W-1];
  for (genvar i = 0; i < DATA_W - 1; i++) begin : g_gray
    assign gray_w[i] = rdata_i[i] ^ rdata_i[i+1];
  end

  always_comb begin
    unique case (code_i)
      CODE_TWOS: coded = rdata_i ^ {1'b1, {(DATA_W-1){1'b0}}};
      CODE_GRAY: coded = gray_w;
      default:   coded = rdata_i;
    endcase
  end

  always_comb begin
    word_d   = word_q;
    pdat_d   = pdat_q;
    pclk_d   = pclk_q;
    pvalid_d = pvalid_q;
    if (ev_i.load) begin
      word_d   = coded;
      pvalid_d = 1'b1;
      pdat_d   = ddr_i ? {{(DATA_W-HALF_W){1'b0}}, coded[DATA_W-1:HALF_W]} : coded;
    end
    if (ev_i.rise) pclk_d = 1'b1;
    if (ev_i.swap && ddr_i) pdat_d = {{(DATA_W-HALF_W){1'b0}}, word_q[HALF_W-1:0]};
    if (ev_i.fall) pclk_d = 1'b0;
    if (ev_i.close) begin
      pvalid_d = 1'b0;
      pdat_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      pdat_q   <= '0;
      pclk_q   <= 1'b0;
      pvalid_q <= 1'b0;
    end else begin
      word_q   <= word_d;
      pdat_q   <= pdat_d;
      pclk_q   <= pclk_d;
      pvalid_q <= pvalid_d;
    end
  end

  assign pdat_o   = pdat_q;
  assign pclk_o   = pclk_q;
  assign pvalid_o = pvalid_q;

  assert_clk_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pclk_o) |-> pvalid_o);
  assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pvalid_o && $past(pvalid_o) && !ddr_i) |-> $stable(pdat_o));
  assert_ddr_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pvalid_o && ddr_i) |-> (pdat_o[DATA_W-1:HALF_W] == '0));
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pvalid_o |-> (pdat_o == '0 && !pclk_o));

endmodule

// File: rtl/snap_capture_buf.sv
module snap_capture_buf
  import snap_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              stream_mode_i,
  input  logic              arm_i,
  input  logic              fill_i,
  input  logic              dump_i,
  input  logic [1:0]        code_sel_i,
  input  logic              ddr_mode_i,
  output logic              full_o,
  output logic              empty_o,
  output logic [DATA_W-1:0] pdat_o,
  output logic              pclk_o,
  output logic              pvalid_o
);
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic              re;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] rdata;
  slot_ev_t          ev;
  snap_code_e        code;
  logic              ddr;

  snap_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .stream_mode_i (stream_mode_i),
    .arm_i         (arm_i),
    .fill_i        (fill_i),
    .dump_i        (dump_i),
    .code_sel_i    (code_sel_i),
    .ddr_mode_i    (ddr_mode_i),
    .we_o          (we),
    .waddr_o       (waddr),
    .re_o          (re),
    .raddr_o       (raddr),
    .ev_o          (ev),
    .code_o        (code),
    .ddr_o         (ddr),
    .full_o        (full_o),
    .empty_o       (empty_o)
  );

  snap_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (sample_i),
    .re_i    (re),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  snap_fmt #(.DATA_W(DATA_W)) i_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_i     (ev),
    .code_i   (code),
    .ddr_i    (ddr),
    .rdata_i  (rdata),
    .pdat_o   (pdat_o),
    .pclk_o   (pclk_o),
    .pvalid_o (pvalid_o)
  );

endmodule

// File: tb/test_snap_capture_buf.sv
`timescale 1ns/1ps
module test_snap_capture_buf;
  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] smp = '0;
  logic        stream_mode = 1'b0, arm = 1'b0, fill = 1'b0, dump = 1'b0, ddr = 1'b0;
  logic [1:0]  code = 2'd0;
  logic        full, empty, pclk, pvalid;
  logic [11:0] pdat;

  int n_cmp = 0, n_bad = 0, cyc = 0, tick = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  snap_capture_buf #(.DATA_W(12), .ADDR_W(AW)) i_snap_capture_buf (
    .clk(clk), .rst_n(rst_n), .sample_i(smp), .stream_mode_i(stream_mode),
    .arm_i(arm), .fill_i(fill), .dump_i(dump), .code_sel_i(code),
    .ddr_mode_i(ddr), .full_o(full), .empty_o(empty), .pdat_o(pdat),
    .pclk_o(pclk), .pvalid_o(pvalid));

  function automatic logic [11:0] enc(logic [11:0] b, logic [1:0] c);
    logic [11:0] g;
    if (c == 2'd1) return b ^ 12'h800;
    if (c == 2'd2) begin
      g[11] = b[11];
      for (int i = 10; i >= 0; i--) g[i] = b[i+1] ^ b[i];
      return g;
    end
    return b;
  endfunction

  function automatic logic [11:0] ungray(logic [11:0] g);
    logic [11:0] b;
    b[11] = g[11];
    for (int i = 10; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference model
  int          m_state = 0;
  int          m_ph = 0;
  logic [11:0] m_q[$];
  logic [11:0] m_word;
  logic [1:0]  m_code;
  bit          m_ddr;
  logic [11:0] e_pdat = '0;
  bit          e_pclk = 0, e_pvalid = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_ph = 0; m_q.delete();
      e_pdat = '0; e_pclk = 0; e_pvalid = 0;
    end else begin
      case (m_state)
        0: if (dump && m_q.size() > 0) begin
             m_state = 3; m_ph = 0; m_code = code; m_ddr = ddr;
           end else if (arm || (fill && !stream_mode)) begin
             m_q.delete(); m_state = stream_mode ? 2 : 1;
           end
        1: begin
             m_q.push_back(smp);
             if (m_q.size() == DEPTH) m_state = 0;
           end
        2: if (fill) m_state = 0;
           else begin
             m_q.push_back(smp);
             if (m_q.size() > DEPTH) void'(m_q.pop_front());
           end
        default: begin
          case (m_ph)
            1: begin
                 m_word = enc(m_q[0], m_code); e_pvalid = 1;
                 e_pdat = m_ddr ? {6'd0, m_word[11:6]} : m_word;
               end
            3: e_pclk = 1;
            4: if (m_ddr) e_pdat = {6'd0, m_word[5:0]};
            6: e_pclk = 0;
            7: begin
                 void'(m_q.pop_front()); e_pvalid = 0; e_pdat = '0;
                 if (m_q.size() == 0) m_state = 0;
               end
            default: ;
          endcase
          m_ph = (m_ph + 1) % 8;
        end
      endcase
    end
  end

  // Per-clock comparison and word collector
  logic [11:0] got[$];
  bit prev_v = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(pdat == e_pdat, "R5 R7 R8 pdat", pdat, e_pdat);
      check(pclk == e_pclk, "R8 pclk", pclk, e_pclk);
      check(pvalid == e_pvalid, "R5 pvalid", pvalid, e_pvalid);
      check(full == (m_q.size() == DEPTH), "R10 full", full, m_q.size() == DEPTH);
      check(empty == (m_q.size() == 0), "R6 R10 empty", empty, m_q.size() == 0);
      if (pvalid && !prev_v) got.push_back(pdat);
      prev_v = pvalid;
    end
  end

  always @(negedge clk) begin
    tick++;
    smp <= 12'((tick * 37 + 5) & 12'hFFF);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic do_dump(logic [1:0] c, logic d);
    got.delete();
    @(negedge clk); code = c; ddr = d; dump = 1'b1;
    @(negedge clk); dump = 1'b0;
    while (!(empty && !pvalid)) @(negedge clk);
    idle(3);
  endtask

  task automatic check_steps(string tag, bit gray_in);
    for (int i = 0; i + 1 < got.size(); i++) begin
      logic [11:0] a, b;
      a = gray_in ? ungray(got[i]) : got[i];
      b = gray_in ? ungray(got[i+1]) : got[i+1];
      check(12'(b - a) == 12'd37, tag, 12'(b - a), 37);
    end
  endtask

  initial begin
    logic [11:0] first;
    idle(3);
    // R1: reset state
    check(empty == 1 && full == 0, "R1 flags", {full, empty}, 2'b01);
    check(pvalid == 0 && pclk == 0 && pdat == 0, "R1 outputs", pdat, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R2/R3: one-shot by arm, retrigger mid-capture ignored
    stream_mode = 1'b0;
    pulse(arm);
    idle(4);
    pulse(fill);                        // R3: ignored during capture
    idle(DEPTH - 7);
    check(full == 0, "R2 not yet full", full, 0);
    idle(2);
    check(full == 1, "R2 full after DEPTH", full, 1);

    // R3: arm during dump ignored; R5/R6 parallel offset readout
    fork
      do_dump(2'd0, 1'b0);
      begin idle(20); pulse(arm); end
    join
    check(got.size() == DEPTH, "R6 word count", got.size(), DEPTH);
    check_steps("R5 oldest-first order", 0);
    check(empty == 1, "R3 arm ignored in dump", empty, 1);

    // R9: dump with empty buffer ignored
    do_dump(2'd0, 1'b0);
    check(got.size() == 0, "R9 empty dump", got.size(), 0);

    // R2/R7: one-shot by fill, two's complement readout
    @(negedge clk); fill = 1'b1;
    @(negedge clk); fill = 1'b0; #1 first = smp;
    pulse(dump);                        // R9: ignored during capture
    idle(DEPTH + 2);
    check(full == 1, "R2 fill trigger full", full, 1);
    do_dump(2'd1, 1'b0);
    check(got.size() == DEPTH, "R7 twos count", got.size(), DEPTH);
    if (got.size() > 0)
      check(got[0] == (first ^ 12'h800), "R7 twos first word", got[0], first ^ 12'h800);

    // R4: streaming with wrap, stopped by fill; R8 DDR readout, Gray coding
    stream_mode = 1'b1;
    pulse(fill);                        // R4: fill does not start in streaming mode
    idle(3);
    check(empty == 1, "R4 fill no start", empty, 1);
    pulse(arm);
    idle(3 * DEPTH + 7);
    pulse(fill);
    idle(2);
    check(full == 1, "R4 wrap keeps full", full, 1);
    do_dump(2'd2, 1'b1);
    check(got.size() == DEPTH, "R4 R8 ddr count", got.size(), DEPTH);
    if (got.size() > 0)
      check(got[0][11:6] == 0, "R8 ddr upper zero", got[0], 0);

    // R4: short streaming run, Gray parallel readout keeps order
    pulse(arm);
    idle(9);
    pulse(fill);
    idle(2);
    check(full == 0 && empty == 0, "R4 partial fill", {full, empty}, 0);
    do_dump(2'd2, 1'b0);
    check(got.size() == 10, "R4 partial count", got.size(), 10);
    check_steps("R7 gray order", 1);

    // R7: reserved code reads as offset binary
    stream_mode = 1'b0;
    pulse(arm);
    idle(DEPTH + 2);
    do_dump(2'd3, 1'b0);
    check_steps("R7 reserved code offset", 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule